// File: doc/BRIEF.md
# Per-Carrier QAM Constellation Mapper

This block sits in a multicarrier transmitter between the bit source and the inverse transform. It takes a serial bit stream, cut into words on a valid/ready input, and turns it into one complex constellation point per carrier. Each carrier has its own load, between 0 and 14 bits, held in an allocation table of up to `NUM_CARRIERS` entries. Each point is a signed pair (x, y) of 16-bit two's complement values, and it is sent out with its carrier index on a valid/ready output.

A symbol begins when `sym_start` pulses. The block then walks the carriers from index 0 upward. For each carrier it reads the load n from the table and waits until enough bits are buffered. It then takes those n bits, least significant first, and emits the point. The code k of each axis maps to the odd integer 2k + 1 − 2^m, where m is the number of bits that axis carries. When the load is odd, x takes the extra bit, which gives a rectangular grid. A load of 0 marks an unused carrier: the point is zero and no bits are taken. The point for the highest carrier is flagged as the end of the symbol. The table is written through a plain address/data write port while no symbol is running.

Top module: `qam_carrier_mapper`

## Requirements
- R1: After a synchronous reset, `pt_valid` is low and `in_ready` is high.
- R2: Within a symbol, points leave in ascending carrier order, 0 to `NUM_CARRIERS`−1, and each point carries its carrier number on `pt_idx`.
- R3: For an even load n, bit 2j of the carrier's bit group is bit j of the x code and bit 2j+1 is bit j of the y code. Each axis value is 2k + 1 − 2^(n/2) in 16-bit two's complement, so every non-zero coordinate is odd.
- R4: For an odd load n, the same alternation starting with x gives x (n+1)/2 bits and y (n−1)/2 bits, each following the rule 2k + 1 − 2^m. A load of 1 therefore gives y = 0 and x = ±1.
- R5: A load of 0 gives x = y = 0 and takes no bits from the stream.
- R6: Bit 0 of each `in_bits` word is taken first. The stream is used without gaps across carriers and across symbols, and bits left over after a symbol are kept for the next one.
- R7: `pt_last` is high exactly on the point of carrier `NUM_CARRIERS`−1.
- R8: No point is emitted for a carrier until the buffer holds at least that carrier's load. The block waits for the bits and drops nothing.
- R9: While `pt_valid` is high and `pt_ready` is low, all point fields hold their values.
- R10: A `sym_start` pulse restarts the symbol at carrier 0 from any state, including part-way through a symbol.
- R11: A table entry above 14 (that is, 15) is treated as a load of 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Allocation table write strobe |
| tbl_addr | input | AW | Carrier number to write |
| tbl_nbits | input | NB_W | Bit load for that carrier |
| sym_start | input | 1 | One-cycle pulse that starts a symbol at carrier 0 |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can accept an input word |
| in_bits | input | IN_W | Input bits, bit 0 used first |
| pt_valid | output | 1 | Output point valid |
| pt_ready | input | 1 | Downstream accepts the point |
| pt_x | output | COORD_W | In-phase coordinate, two's complement |
| pt_y | output | COORD_W | Quadrature coordinate, two's complement |
| pt_idx | output | AW | Carrier number of the point |
| pt_last | output | 1 | Point belongs to the last carrier of the symbol |

## Verification
The most dangerous fault is a wrong fill count or a wrong shift in the bit buffer. It does not stay local: every later coordinate, in this symbol and in the ones after it, is built from misaligned bits. The bench therefore checks each point against a model that walks one continuous stream across symbol boundaries. A bad carrier counter or a bad table read shows on the very next point, as a wrong `pt_idx`, a misplaced `pt_last`, or a coordinate of the wrong magnitude. A stall that fails to hold shows within one cycle as a changed field while `pt_ready` is low.

// File: rtl/qmap_pkg.sv
package qmap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_MAP
  } map_state_t;
endpackage

// File: rtl/qmap_alloc_ram.sv
// Bit-allocation store: one write port and one registered read port,
// so that it can be inferred as block RAM.
module qmap_alloc_ram #(
  parameter int DEPTH = 256,
  parameter int DW    = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/qmap_bit_buffer.sv
// Shift buffer: takes up to 'take_n' bits off the low end each cycle
// and appends an input word right above the bits that remain.
module qmap_bit_buffer #(
  parameter int IN_W  = 8,
  parameter int WIN_W = 14,
  localparam int BUF_W = WIN_W + IN_W,
  localparam int CW    = $clog2(BUF_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_bits,
  input  logic             take_en,
  input  logic [CW-1:0]    take_n,
  output logic [CW-1:0]    fill,
  output logic [WIN_W-1:0] window
);
  logic [BUF_W-1:0] store_q;
  logic [CW-1:0]    fill_q;
  logic [CW-1:0]    used;
  logic [CW-1:0]    rem;
  logic [BUF_W-1:0] kept;

  always_comb begin
    used = take_en ? take_n : '0;
    rem  = fill_q - used;
    kept = store_q >> used;
  end

  assign in_ready = (fill_q <= CW'(BUF_W - IN_W));

  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= '0;
      fill_q  <= '0;
    end else if (in_valid && in_ready) begin
      store_q <= kept | (BUF_W'(in_bits) << rem);
      fill_q  <= rem + CW'(IN_W);
    end else begin
      store_q <= kept;
      fill_q  <= rem;
    end
  end

  assign fill   = fill_q;
  assign window = store_q[WIN_W-1:0];
endmodule

// File: rtl/qmap_point_calc.sv
// Splits a carrier's bit group between the two axes and converts each
// axis code to its odd-integer coordinate.
module qmap_point_calc #(
  parameter int MAX_N   = 14,
  parameter int NB_W    = 4,
  parameter int COORD_W = 16,
  localparam int HX     = (MAX_N + 1) / 2,
  localparam int HY     = MAX_N / 2
) (
  input  logic [NB_W-1:0]    nbits,
  input  logic [MAX_N-1:0]   window,
  output logic [COORD_W-1:0] x,
  output logic [COORD_W-1:0] y
);
  logic [HX-1:0]   kx;
  logic [HY-1:0]   ky;
  logic [NB_W-1:0] nx;
  logic [NB_W-1:0] ny;

  for (genvar g = 0; g < HX; g++) begin : g_xbit
    localparam logic [NB_W:0] POS = (NB_W + 1)'(2 * g);
    assign kx[g] = (POS < {1'b0, nbits}) ? window[2*g] : 1'b0;
  end

  for (genvar g = 0; g < HY; g++) begin : g_ybit
    localparam logic [NB_W:0] POS = (NB_W + 1)'(2 * g + 1);
    assign ky[g] = (POS < {1'b0, nbits}) ? window[2*g+1] : 1'b0;
  end

  always_comb begin
    nx = NB_W'(({1'b0, nbits} + (NB_W + 1)'(1)) >> 1);
    ny = nbits >> 1;
    x  = (COORD_W'(kx) << 1) + COORD_W'(1) - (COORD_W'(1) << nx);
    y  = (COORD_W'(ky) << 1) + COORD_W'(1) - (COORD_W'(1) << ny);
  end
endmodule

// File: rtl/qam_carrier_mapper.sv
module qam_carrier_mapper
  import qmap_pkg::*;
#(
  parameter int NUM_CARRIERS = 256,
  parameter int MAX_N        = 14,
  parameter int IN_W         = 8,
  parameter int COORD_W      = 16,
  localparam int AW          = $clog2(NUM_CARRIERS),
  localparam int NB_W        = $clog2(MAX_N + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tbl_we,
  input  logic [AW-1:0]      tbl_addr,
  input  logic [NB_W-1:0]    tbl_nbits,
  input  logic               sym_start,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [IN_W-1:0]    in_bits,
  output logic               pt_valid,
  input  logic               pt_ready,
  output logic [COORD_W-1:0] pt_x,
  output logic [COORD_W-1:0] pt_y,
  output logic [AW-1:0]      pt_idx,
  output logic               pt_last
);
  localparam int BUF_W = MAX_N + IN_W;
  localparam int CW    = $clog2(BUF_W + 1);
  localparam logic [AW-1:0] LAST_IDX = AW'(NUM_CARRIERS - 1);

  map_state_t         state_q;
  logic [AW-1:0]      idx_q;
  logic [NB_W-1:0]    tbl_q;
  logic [NB_W-1:0]    n_eff;
  logic [CW-1:0]      fill;
  logic [MAX_N-1:0]   window;
  logic [COORD_W-1:0] calc_x;
  logic [COORD_W-1:0] calc_y;
  logic               fire;
  logic               last_c;

  qmap_alloc_ram #(.DEPTH(NUM_CARRIERS), .DW(NB_W)) u_table (
    .clk     (clk),
    .wr_en   (tbl_we),
    .wr_addr (tbl_addr),
    .wr_data (tbl_nbits),
    .rd_addr (idx_q),
    .rd_data (tbl_q)
  );

  // Entries above the largest load are clamped.
  assign n_eff  = (tbl_q > NB_W'(MAX_N)) ? NB_W'(MAX_N) : tbl_q;
  assign last_c = (idx_q == LAST_IDX);
  assign fire   = (state_q == ST_MAP) && !sym_start &&
                  (fill >= CW'(n_eff)) && (!pt_valid || pt_ready);

  qmap_bit_buffer #(.IN_W(IN_W), .WIN_W(MAX_N)) u_buffer (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_bits  (in_bits),
    .take_en  (fire),
    .take_n   (CW'(n_eff)),
    .fill     (fill),
    .window   (window)
  );

  qmap_point_calc #(.MAX_N(MAX_N), .NB_W(NB_W), .COORD_W(COORD_W)) u_calc (
    .nbits  (n_eff),
    .window (window),
    .x      (calc_x),
    .y      (calc_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      pt_valid <= 1'b0;
      pt_x     <= '0;
      pt_y     <= '0;
      pt_idx   <= '0;
      pt_last  <= 1'b0;
    end else begin
      if (fire) begin
        pt_valid <= 1'b1;
        pt_x     <= calc_x;
        pt_y     <= calc_y;
        pt_idx   <= idx_q;
        pt_last  <= last_c;
      end else if (pt_ready) begin
        pt_valid <= 1'b0;
      end

      if (sym_start) begin
        idx_q   <= '0;
        state_q <= ST_READ;
      end else begin
        case (state_q)
          ST_READ: state_q <= ST_MAP;
          ST_MAP: begin
            if (fire) begin
              if (last_c) begin
                state_q <= ST_IDLE;
              end else begin
                idx_q   <= idx_q + AW'(1);
                state_q <= ST_READ;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/qam_carrier_mapper_checker.sv
module qam_carrier_mapper_checker #(
  parameter int NUM_CARRIERS = 256,
  parameter int COORD_W      = 16,
  localparam int AW          = $clog2(NUM_CARRIERS)
) (
  input logic               clk,
  input logic               rst,
  input logic               in_ready,
  input logic               pt_valid,
  input logic               pt_ready,
  input logic [COORD_W-1:0] pt_x,
  input logic [COORD_W-1:0] pt_y,
  input logic [AW-1:0]      pt_idx,
  input logic               pt_last
);
  localparam logic [AW-1:0] LAST_IDX = AW'(NUM_CARRIERS - 1);

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!pt_valid && in_ready));

  assert_hold_stall_R9: assert property (@(posedge clk) disable iff (rst)
    (pt_valid && !pt_ready) |=> (pt_valid && $stable(pt_x) && $stable(pt_y) &&
                                 $stable(pt_idx) && $stable(pt_last)));

  assert_last_idx_R7: assert property (@(posedge clk) disable iff (rst)
    (pt_valid && pt_last) |-> (pt_idx == LAST_IDX));

  assert_last_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (pt_valid && pt_idx == LAST_IDX) |-> pt_last);

  assert_odd_coord_R3: assert property (@(posedge clk) disable iff (rst)
    pt_valid |-> ((pt_x[0] || pt_x == '0) && (pt_y[0] || pt_y == '0)));
endmodule

bind qam_carrier_mapper qam_carrier_mapper_checker #(
  .NUM_CARRIERS (NUM_CARRIERS),
  .COORD_W      (COORD_W)
) u_checker (
  .clk      (clk),
  .rst      (rst),
  .in_ready (in_ready),
  .pt_valid (pt_valid),
  .pt_ready (pt_ready),
  .pt_x     (pt_x),
  .pt_y     (pt_y),
  .pt_idx   (pt_idx),
  .pt_last  (pt_last)
);

// File: tb/qam_carrier_mapper_bench.sv
`timescale 1ns/1ps
module qam_carrier_mapper_bench;
  localparam int NC   = 16;
  localparam int MAXN = 14;
  localparam int INW  = 8;
  localparam int CRDW = 16;
  localparam int AW   = $clog2(NC);
  localparam int NBW  = $clog2(MAXN + 1);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            tbl_we = 1'b0;
  logic [AW-1:0]   tbl_addr = '0;
  logic [NBW-1:0]  tbl_nbits = '0;
  logic            sym_start = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [INW-1:0]  in_bits = '0;
  logic            pt_valid;
  logic            pt_ready = 1'b0;
  logic [CRDW-1:0] pt_x;
  logic [CRDW-1:0] pt_y;
  logic [AW-1:0]   pt_idx;
  logic            pt_last;

  qam_carrier_mapper #(.NUM_CARRIERS(NC), .MAX_N(MAXN), .IN_W(INW), .COORD_W(CRDW))
    u_qam_carrier_mapper (
    .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_nbits(tbl_nbits),
    .sym_start(sym_start), .in_valid(in_valid), .in_ready(in_ready), .in_bits(in_bits),
    .pt_valid(pt_valid), .pt_ready(pt_ready), .pt_x(pt_x), .pt_y(pt_y),
    .pt_idx(pt_idx), .pt_last(pt_last)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int tbl [NC];
  bit stream_q [$];
  int mpos = 0;
  int sent = 0;
  int ex_x [$];
  int ex_y [$];
  int ex_n [$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int clampn(input int v);
    return (v > MAXN) ? MAXN : v;
  endfunction

  function automatic int coord(input int k, input int nb);
    return 2 * k + 1 - (1 << nb);
  endfunction

  // Builds expected points for carriers 0..npts-1 from the continuous stream.
  task automatic build(input int npts);
    int need = 0;
    ex_x.delete(); ex_y.delete(); ex_n.delete();
    for (int c = 0; c < npts; c++) need += clampn(tbl[c]);
    while (stream_q.size() < mpos + need)
      for (int i = 0; i < INW; i++) stream_q.push_back(1'($urandom % 2));
    for (int c = 0; c < npts; c++) begin
      int n = clampn(tbl[c]);
      int kx = 0;
      int ky = 0;
      for (int j = 0; j < n; j++) begin
        if (j % 2 == 0) kx |= int'(stream_q[mpos + j]) << (j / 2);
        else            ky |= int'(stream_q[mpos + j]) << (j / 2);
      end
      ex_n.push_back(n);
      ex_x.push_back(coord(kx, (n + 1) / 2));
      ex_y.push_back(coord(ky, n / 2));
      mpos += n;
    end
  endtask

  task automatic write_table();
    for (int c = 0; c < NC; c++) begin
      @(negedge clk);
      tbl_we = 1'b1; tbl_addr = AW'(c); tbl_nbits = NBW'(tbl[c]);
    end
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); sym_start = 1'b1;
    @(negedge clk); sym_start = 1'b0;
  endtask

  task automatic drive(input int vld_pct);
    while (sent + INW <= stream_q.size()) begin
      bit acc;
      @(negedge clk);
      in_valid = (($urandom % 100) < vld_pct);
      for (int i = 0; i < INW; i++) in_bits[i] = stream_q[sent + i];
      #1;
      acc = in_valid && in_ready;
      @(posedge clk);
      if (acc) sent += INW;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic collect(input int npts, input int rdy_pct, input string idx_tag);
    int got = 0;
    bit hold = 0;
    logic [CRDW-1:0] hx, hy;
    logic [AW-1:0] hi;
    logic hl;
    while (got < npts) begin
      @(negedge clk);
      pt_ready = (($urandom % 100) < rdy_pct);
      #1;
      if (hold)
        check(pt_valid && pt_x == hx && pt_y == hy && pt_idx == hi && pt_last == hl,
              "R9", "point held under backpressure", int'(pt_x), int'(hx));
      if (pt_valid && pt_ready) begin
        int n = ex_n[got];
        string tag = (n == 0) ? "R5" : ((n % 2 == 1) ? "R4" : "R3");
        tag = $sformatf("%s R6", tag);
        check(int'(pt_idx) == got, (got == 0) ? idx_tag : "R2", "carrier index",
              int'(pt_idx), got);
        check(int'($signed(pt_x)) == ex_x[got], tag, $sformatf("x of carrier %0d", got),
              int'($signed(pt_x)), ex_x[got]);
        check(int'($signed(pt_y)) == ex_y[got], tag, $sformatf("y of carrier %0d", got),
              int'($signed(pt_y)), ex_y[got]);
        check(pt_last == (got == NC - 1), "R7", "end-of-symbol flag",
              int'(pt_last), int'(got == NC - 1));
        got++;
      end
      hold = pt_valid && !pt_ready;
      hx = pt_x; hy = pt_y; hi = pt_idx; hl = pt_last;
      @(posedge clk);
    end
    @(negedge clk);
    pt_ready = 1'b0;
  endtask

  task automatic run(input int npts, input int vld_pct, input int rdy_pct,
                     input string idx_tag);
    build(npts);
    pulse_start();
    fork
      drive(vld_pct);
      collect(npts, rdy_pct, idx_tag);
    join
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h0005_EED1));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(pt_valid == 1'b0, "R1", "pt_valid after reset", int'(pt_valid), 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);

    // Even loads, no backpressure.
    for (int c = 0; c < NC; c++) tbl[c] = 2 * (1 + $urandom % 7);
    write_table();
    run(NC, 100, 100, "R2");

    // Odd loads including 1.
    for (int c = 0; c < NC; c++) tbl[c] = 1 + 2 * ($urandom % 7);
    tbl[0] = 1; tbl[NC-1] = 13;
    write_table();
    run(NC, 80, 70, "R2");

    // Unused carriers, clamped entries, mixed loads, backpressure.
    for (int c = 0; c < NC; c++) tbl[c] = (c % 4 == 0) ? 0 : ((c % 4 == 1) ? 15 : $urandom % 15);
    write_table();
    run(NC, 60, 50, "R11");

    // All carriers unused: no bits taken.
    for (int c = 0; c < NC; c++) tbl[c] = 0;
    write_table();
    run(NC, 100, 100, "R5");

    // Starvation: carrier 0 needs more bits than are buffered.
    for (int c = 0; c < NC; c++) tbl[c] = 14;
    write_table();
    pulse_start();
    if (stream_q.size() - mpos < 6)
      for (int i = 0; i < INW; i++) stream_q.push_back(1'($urandom % 2));
    drive(100);
    repeat (20) @(negedge clk);
    check(pt_valid == 1'b0, "R8", "no point while bits are short", int'(pt_valid), 0);
    run(NC, 50, 70, "R8");

    // Restart in the middle of a symbol.
    for (int c = 0; c < NC; c++) tbl[c] = (c < 4) ? 2 : 14;
    write_table();
    run(4, 100, 100, "R2");
    repeat (10) @(negedge clk);
    check(pt_valid == 1'b0, "R8", "stalled at carrier 4", int'(pt_valid), 0);
    for (int c = 0; c < NC; c++) tbl[c] = $urandom % 15;
    write_table();
    run(NC, 90, 90, "R10");

    // Random symbols.
    for (int s = 0; s < 6; s++) begin
      for (int c = 0; c < NC; c++) tbl[c] = $urandom % 16;
      write_table();
      run(NC, 40 + $urandom % 61, 40 + $urandom % 61, "R2");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule